// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Occupancy Flags

This block carries data words from a producer clock domain to a consumer clock domain. Words go into a dual-port storage array of `2**ADDR_W` entries. One output register sits after the array. As soon as a word reaches the read side it is moved into that register and shown on `rd_data` with no read request. The consumer sees a valid word whenever `out_ready_n` is low. Raising `rd_en` in that state takes the shown word and brings the next one forward. Because the output register holds a word of its own, the block stores `2**ADDR_W + 1` words in total (called D below).

The producer writes with `wr_en` while `in_ready_n` is low. The write side also drives a half-full flag and a programmable almost-full flag. The read side drives a programmable almost-empty flag. Both thresholds are sampled from their input ports while reset is held. Write and read positions cross between the domains as Gray-coded counters through two-flop synchronizers. Each flag is computed in the domain of the side that uses it, so it reacts to the other side a fixed small number of cycles later.

Top module: `fifo_fwft_dc`

## Requirements
- R1: While `rst_n` is low and for the first cycles after it rises, `out_ready_n` = 1, `in_ready_n` = 0, `almost_empty` = 1, `almost_full` = 0 and `half_full` = 0.
- R2: Words leave in the order they were accepted. The oldest held word is present on `rd_data` with `out_ready_n` = 0 without any `rd_en`. It stays unchanged until a cycle with `rd_en` = 1 takes it.
- R3: With no reads, the FIFO accepts exactly D = `2**ADDR_W + 1` words. After that, `in_ready_n` stays 1.
- R4: A write presented while `in_ready_n` = 1 is dropped. It does not corrupt stored words and does not change the count.
- R5: `rd_en` pulses while `out_ready_n` = 1 are ignored. A word written afterwards still comes out first and intact.
- R6: With both sides idle, `almost_empty` = 1 exactly when the held word count is at most `ae_offset`, the value sampled during reset.
- R7: With both sides idle, `almost_full` = 1 exactly when the held word count is at least D minus `af_offset`, the value sampled during reset.
- R8: With both sides idle, `half_full` = 1 exactly when the held count is greater than D/2 rounded down.
- R9: After a read frees space in a full FIFO, `in_ready_n` returns to 0 within 5 write-clock cycles.
- R10: After a write into an empty FIFO, `out_ready_n` goes to 0 within 5 read-clock cycles, with the written word on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| ae_offset | input | ADDR_W+2 | Almost-empty threshold, captured while reset is low |
| af_offset | input | ADDR_W+2 | Almost-full free-space threshold, captured while reset is low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| in_ready_n | output | 1 | Low while a write will be accepted |
| half_full | output | 1 | Held count above half of D (write side) |
| almost_full | output | 1 | Free space at or below `af_offset` (write side) |
| rd_en | input | 1 | Take the word shown on `rd_data` |
| rd_data | output | DATA_W | Oldest held word |
| out_ready_n | output | 1 | Low while `rd_data` holds a valid word |
| almost_empty | output | 1 | Held count at or below `ae_offset` (read side) |

## Verification
Some internal faults show up at the ports at once. A stale or wrong fetch pointer puts a word out of order on `rd_data` at the next take, and the per-word comparison catches it on that read. A read-side pointer that moves while the output is empty has the same effect. A wrong count, a bad Gray conversion or a lost synchronizer stage shows up only once traffic stops. It then appears as a flag or ready level that is wrong for the known count, and the bench looks for it after every idle settle and at each fill level of the stepwise sweep. Lag in a pointer crossing would stretch the recovery times measured for R9 and R10 past their bounds, within a handful of cycles.

// File: rtl/fifo_fwft_pkg.sv
// Package: shared helpers for the dual-clock FIFO.
// Assumes: pointers are no wider than 32 bits.
package fifo_fwft_pkg;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary; zero upper bits stay zero.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

endpackage

// File: rtl/fifo_ptr_xing.sv
// Module: moves a binary counter from one clock domain to another.
// It registers the Gray code of the counter's next value in the source domain,
// then passes it through a two-flop synchronizer in the destination domain.
// Assumes: the counter changes by at most one per source clock.
module fifo_ptr_xing #(
    parameter int W = 6
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_bin_nxt,
    output logic [W-1:0] dst_bin
);
    import fifo_fwft_pkg::*;

    logic [W-1:0] gray_src;
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [31:0]  bin_wide;

    // Source register: Gray code that tracks the counter edge for edge.
    always_ff @(posedge src_clk) begin
        if (!rst_n) gray_src <= '0;
        else        gray_src <= W'(to_gray(32'(src_bin_nxt)));
    end

    // Two-stage synchronizer in the destination domain.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_src;
            sync_q <= meta_q;
        end
    end

    // Decode back to binary for arithmetic in the destination domain.
    always_comb bin_wide = from_gray(32'(sync_q));
    assign dst_bin = bin_wide[W-1:0];
endmodule

// File: rtl/fifo_store.sv
// Module: dual-port storage array, synchronous write and combinational read.
// Assumes: the caller never writes an occupied slot.
module fifo_store #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int ENTRIES = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [ENTRIES];

    // Write port: one word per producer clock.
    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
// Module: producer-side control. It owns the write pointer and drives
// the ready, half-full and almost-full flags.
// Assumes: fetch_s counts words moved out of the array, and cons_s counts
// words that have left the block, both synchronized to wr_clk.
module fifo_wr_side #(
    parameter int ADDR_W = 4,
    parameter int PTR_W  = ADDR_W + 2
) (
    input  logic             wr_clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] af_offset,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] fetch_s,
    input  logic [PTR_W-1:0] cons_s,
    output logic             mem_we,
    output logic [PTR_W-1:0] w_bin,
    output logic [PTR_W-1:0] w_bin_nxt,
    output logic             in_ready_n,
    output logic             half_full,
    output logic             almost_full
);
    localparam int ARR   = 1 << ADDR_W;
    localparam int DEPTH = ARR + 1;
    localparam int HALF  = DEPTH / 2;

    logic [PTR_W-1:0] af_q;
    logic [PTR_W-1:0] arr_cnt;
    logic [PTR_W-1:0] tot_cnt;
    logic [PTR_W:0]   af_sum;

    // Occupancy as seen from the producer side (pessimistic, never low).
    always_comb begin
        arr_cnt     = w_bin - fetch_s;
        tot_cnt     = w_bin - cons_s;
        af_sum      = {1'b0, tot_cnt} + {1'b0, af_q};
        in_ready_n  = (arr_cnt == PTR_W'(ARR));
        half_full   = (tot_cnt > PTR_W'(HALF));
        almost_full = (af_sum >= (PTR_W + 1)'(DEPTH));
        mem_we      = wr_en && !in_ready_n;
        w_bin_nxt   = w_bin + PTR_W'(mem_we);
    end

    // Pointer advance and capture of the threshold during reset.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            w_bin <= '0;
            af_q  <= af_offset;
        end else begin
            w_bin <= w_bin_nxt;
        end
    end
endmodule

// File: rtl/fifo_rd_side.sv
// Module: consumer-side control. It moves a word from the array into the
// output register as soon as one is there, and drives the output-ready
// and almost-empty flags.
// Assumes: w_s is the write pointer synchronized to rd_clk.
module fifo_rd_side #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4,
    parameter int PTR_W  = ADDR_W + 2
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  ae_offset,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  w_s,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  fetch_nxt,
    output logic [PTR_W-1:0]  c_bin,
    output logic [PTR_W-1:0]  c_bin_nxt,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_ready_n,
    output logic              almost_empty
);
    logic [PTR_W-1:0] fetch_q;
    logic [PTR_W-1:0] ae_q;
    logic             valid_q;
    logic             take;
    logic             load;

    // Take, refill and pointer next values.
    always_comb begin
        take         = rd_en && valid_q;
        load         = (w_s != fetch_q) && (!valid_q || take);
        fetch_nxt    = fetch_q + PTR_W'(load);
        c_bin_nxt    = c_bin + PTR_W'(take);
        raddr        = fetch_q[ADDR_W-1:0];
        out_ready_n  = !valid_q;
        almost_empty = ((w_s - c_bin) <= ae_q);
    end

    // Output register, its valid bit, both pointers, and threshold capture.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            fetch_q <= '0;
            c_bin   <= '0;
            valid_q <= 1'b0;
            rd_data <= '0;
            ae_q    <= ae_offset;
        end else begin
            fetch_q <= fetch_nxt;
            c_bin   <= c_bin_nxt;
            if (load)      valid_q <= 1'b1;
            else if (take) valid_q <= 1'b0;
            if (load)      rd_data <= mem_q;
        end
    end
endmodule

// File: rtl/fifo_fwft_dc.sv
// Module: dual-clock first-word-fall-through FIFO, depth 2**ADDR_W + 1.
// Assumes: rst_n is held low for several cycles of both clocks.
module fifo_fwft_dc #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4,
    localparam int PTR_W = ADDR_W + 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  ae_offset,
    input  logic [PTR_W-1:0]  af_offset,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              in_ready_n,
    output logic              half_full,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_ready_n,
    output logic              almost_empty
);
    logic              mem_we;
    logic [PTR_W-1:0]  w_bin;
    logic [PTR_W-1:0]  w_bin_nxt;
    logic [PTR_W-1:0]  w_sync_r;
    logic [PTR_W-1:0]  f_nxt;
    logic [PTR_W-1:0]  f_sync_w;
    logic [PTR_W-1:0]  c_bin;
    logic [PTR_W-1:0]  c_bin_nxt;
    logic [PTR_W-1:0]  c_sync_w;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] mem_q;

    fifo_wr_side #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) wr_i (
        .wr_clk(wr_clk), .rst_n(rst_n), .af_offset(af_offset), .wr_en(wr_en),
        .fetch_s(f_sync_w), .cons_s(c_sync_w), .mem_we(mem_we), .w_bin(w_bin),
        .w_bin_nxt(w_bin_nxt), .in_ready_n(in_ready_n), .half_full(half_full),
        .almost_full(almost_full)
    );

    fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .wr_clk(wr_clk), .we(mem_we), .waddr(w_bin[ADDR_W-1:0]), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    fifo_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) rd_i (
        .rd_clk(rd_clk), .rst_n(rst_n), .ae_offset(ae_offset), .rd_en(rd_en),
        .w_s(w_sync_r), .mem_q(mem_q), .raddr(raddr), .fetch_nxt(f_nxt),
        .c_bin(c_bin), .c_bin_nxt(c_bin_nxt), .rd_data(rd_data),
        .out_ready_n(out_ready_n), .almost_empty(almost_empty)
    );

    // Write position toward the read domain.
    fifo_ptr_xing #(.W(PTR_W)) x_w2r (
        .src_clk(wr_clk), .dst_clk(rd_clk), .rst_n(rst_n),
        .src_bin_nxt(w_bin_nxt), .dst_bin(w_sync_r)
    );

    // Array-release position toward the write domain (governs in_ready_n).
    fifo_ptr_xing #(.W(PTR_W)) x_f2w (
        .src_clk(rd_clk), .dst_clk(wr_clk), .rst_n(rst_n),
        .src_bin_nxt(f_nxt), .dst_bin(f_sync_w)
    );

    // Block-exit position toward the write domain (governs count flags).
    fifo_ptr_xing #(.W(PTR_W)) x_c2w (
        .src_clk(rd_clk), .dst_clk(wr_clk), .rst_n(rst_n),
        .src_bin_nxt(c_bin_nxt), .dst_bin(c_sync_w)
    );
endmodule

// File: rtl/fifo_fwft_dc_chk.sv
// Checker: temporal properties of the FIFO, bound into every instance.
// Assumes: connected by name to the top module's ports and pointer nets.
module fifo_fwft_dc_chk #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4,
    parameter int PTR_W  = ADDR_W + 2
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              in_ready_n,
    input logic              half_full,
    input logic              out_ready_n,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  w_bin,
    input logic [PTR_W-1:0]  f_sync_w,
    input logic [PTR_W-1:0]  w_sync_r,
    input logic [PTR_W-1:0]  c_bin
);
    localparam int ARR   = 1 << ADDR_W;
    localparam int DEPTH = ARR + 1;

    // R4: the array never holds more than its slot count.
    assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (PTR_W'(w_bin - f_sync_w) <= PTR_W'(ARR)));

    // R3: the read side never sees more than D words held.
    assert_depth_bound_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (PTR_W'(w_sync_r - c_bin) <= PTR_W'(DEPTH)));

    // R5: with no valid output, the exit pointer does not move.
    assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        out_ready_n |=> (c_bin == $past(c_bin)));

    // R2: a shown word is held until it is taken.
    assert_hold_word_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!out_ready_n && !rd_en) |=> (!out_ready_n && $stable(rd_data)));

    // R8: below half full, the write side is always ready.
    assert_half_ready_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !half_full |-> !in_ready_n);
endmodule

bind fifo_fwft_dc fifo_fwft_dc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) chk_i (.*);

// File: tb/fifo_fwft_dc_tb_top.sv
// Bench: directed corner cases followed by seeded random traffic,
// checked against a queue model of the FIFO.
module fifo_fwft_dc_tb_top;
    localparam int DATA_W = 18;
    localparam int ADDR_W = 4;
    localparam int PTR_W  = ADDR_W + 2;
    localparam int DEPTH  = (1 << ADDR_W) + 1;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              rst_n  = 1'b0;
    logic [PTR_W-1:0]  ae_offset = '0;
    logic [PTR_W-1:0]  af_offset = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic              in_ready_n, half_full, almost_full, out_ready_n, almost_empty;
    logic [DATA_W-1:0] rd_data;

    int vectors = 0;
    int miscompares = 0;
    int ae_n, af_m;
    logic [DATA_W-1:0] model[$];

    always #10 wr_clk = ~wr_clk;
    always #7  rd_clk = ~rd_clk;

    fifo_fwft_dc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (.*);

    // One comparison: count it, report a mismatch.
    task automatic check(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected flag values for a given held count.
    function automatic logic exp_ae(input int c); return c <= ae_n; endfunction
    function automatic logic exp_af(input int c); return c >= DEPTH - af_m; endfunction
    function automatic logic exp_hf(input int c); return c > DEPTH / 2; endfunction

    task automatic do_reset(input int ae, input int af);
        ae_n = ae; af_m = af;
        ae_offset = PTR_W'(ae); af_offset = PTR_W'(af);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (6) @(negedge wr_clk);
        model.delete();
        rst_n = 1'b1;
        ae_offset = '0; af_offset = '1;
    endtask

    task automatic settle();
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (8) @(negedge wr_clk);
        @(negedge rd_clk);
    endtask

    // Compare every flag with the model when both sides are idle.
    task automatic check_flags();
        int c;
        c = model.size();
        check(almost_empty == exp_ae(c), "R6 almost_empty", almost_empty, exp_ae(c));
        check(almost_full == exp_af(c), "R7 almost_full", almost_full, exp_af(c));
        check(half_full == exp_hf(c), "R8 half_full", half_full, exp_hf(c));
        check(in_ready_n == (c == DEPTH), "R3 in_ready_n", in_ready_n, c == DEPTH);
        check(out_ready_n == (c == 0), "R2 out_ready_n", out_ready_n, c == 0);
    endtask

    task automatic write_one(input logic [DATA_W-1:0] d);
        @(negedge wr_clk);
        while (in_ready_n) @(negedge wr_clk);
        wr_en = 1'b1; wr_data = d; model.push_back(d);
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic read_one();
        @(negedge rd_clk);
        while (out_ready_n) @(negedge rd_clk);
        check(model.size() > 0 && rd_data == model[0], "R2 read data", rd_data,
              model.size() > 0 ? model[0] : -1);
        rd_en = 1'b1;
        if (model.size() > 0) void'(model.pop_front());
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    // Random traffic with given write and read percentages.
    task automatic traffic(input int pw, input int pr, input int cycles);
        fork
            begin
                repeat (cycles) begin
                    @(negedge wr_clk);
                    wr_en = (($urandom % 100) < pw);
                    wr_data = DATA_W'($urandom);
                    if (wr_en && !in_ready_n) model.push_back(wr_data);
                end
                @(negedge wr_clk); wr_en = 1'b0;
            end
            begin
                repeat (cycles) begin
                    @(negedge rd_clk);
                    if (!out_ready_n)
                        check(model.size() > 0 && rd_data == model[0], "R2 random order",
                              rd_data, model.size() > 0 ? model[0] : -1);
                    rd_en = (($urandom % 100) < pr);
                    if (rd_en && !out_ready_n && model.size() > 0) void'(model.pop_front());
                end
                @(negedge rd_clk); rd_en = 1'b0;
            end
        join
        settle();
        check_flags();
    endtask

    task automatic run_all();
        int n;
        int acc;
        void'($urandom(32'd4242));
        do_reset(3, 2);
        @(negedge rd_clk);
        // R1: reset levels.
        check(out_ready_n == 1'b1, "R1 out_ready_n", out_ready_n, 1);
        check(in_ready_n == 1'b0, "R1 in_ready_n", in_ready_n, 0);
        check(almost_empty == 1'b1, "R1 almost_empty", almost_empty, 1);
        check(almost_full == 1'b0, "R1 almost_full", almost_full, 0);
        check(half_full == 1'b0, "R1 half_full", half_full, 0);

        // R5: read pulses while empty.
        rd_en = 1'b1;
        repeat (5) @(negedge rd_clk);
        rd_en = 1'b0;
        check(out_ready_n == 1'b1, "R5 still empty", out_ready_n, 1);

        // R10: fall-through latency of the first word.
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = 18'h2A5C3; model.push_back(wr_data);
        @(negedge wr_clk);
        wr_en = 1'b0;
        n = 0;
        while (out_ready_n && n < 20) begin @(negedge rd_clk); n++; end
        check(n <= 5, "R10 fall-through cycles", n, 5);
        check(rd_data == 18'h2A5C3, "R5 R10 first word", rd_data, 18'h2A5C3);
        read_one();
        settle();
        check_flags();

        // R6 R7 R8: flag levels at every fill count, up and down.
        for (int k = 1; k <= DEPTH; k++) begin
            write_one(DATA_W'(k * 37 + 5));
            settle();
            check_flags();
        end

        // R3 R4: extra writes at full are dropped.
        acc = 0;
        repeat (6) begin
            @(negedge wr_clk);
            wr_en = 1'b1; wr_data = 18'h3FFFF;
            if (!in_ready_n) acc++;
        end
        @(negedge wr_clk); wr_en = 1'b0;
        check(acc == 0, "R4 accepted at full", acc, 0);
        check(model.size() == DEPTH, "R3 capacity", model.size(), DEPTH);

        // R9: ready recovers after one read.
        read_one();
        n = 0;
        while (in_ready_n && n < 20) begin @(negedge wr_clk); n++; end
        check(n <= 5, "R9 ready recovery cycles", n, 5);
        settle();
        check_flags();

        for (int k = 0; k < DEPTH - 1; k++) begin
            read_one();
            settle();
            check_flags();
        end

        // Random traffic, two offset settings.
        traffic(80, 30, 400);
        traffic(30, 80, 400);
        traffic(60, 60, 600);
        do_reset(6, 5);
        @(negedge rd_clk);
        check(almost_empty == 1'b1, "R1 second reset", almost_empty, 1);
        traffic(90, 20, 300);
        traffic(50, 50, 600);
        traffic(10, 90, 300);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge wr_clk);
                miscompares++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule